// File: doc/BRIEF.md
# Clock Generator Configuration Target on a Two-Wire Bus

This block is the serial configuration port of a multi-output clock generator. It oversamples the two bus lines (SCL and SDA) with the fast system clock, cleans them through a synchroniser and a two-sample agreement filter, and recognises START, repeated START and STOP. It answers to a 7-bit device address whose two upper bits are fixed ones and whose five lower bits come from strap inputs.

A write carries a register-address byte, which loads an internal pointer, and one data byte that lands in the addressed register. A read sets the pointer with a write-form header, issues a repeated START with the read bit set, and receives one byte from the target, most significant bit first. The register file holds one frequency-select byte per clock output, at addresses 0 up to the output count minus one, plus a single margin byte at 0x10 that applies to every output. All are exported as parallel outputs for the synthesis logic. The target pulls SDA low only through an open-drain enable.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset every frequency-select byte and the margin byte read 0x00 and `sda_oe_o` is low.
- R2: The target acknowledges only the address 1,1,strap[4:0] (MSB first); on any other address it never asserts `sda_oe_o` and ignores all bits until the next START or STOP, so no register changes.
- R3: In a write, the byte after the address sets the pointer and the following byte is stored into frequency-select slot n when the pointer equals n; the new value appears on `freq_sel_o[8n+7:8n]` one system clock after `sda_oe_o` rises for that byte's acknowledge, and not earlier.
- R4: A write to address 0x10 updates `margin_o` and leaves every frequency-select byte unchanged.
- R5: After a pointer write, a repeated START and the address with the read bit set (bit 0 = 1), the target drives the addressed register onto SDA MSB first, one bit per SCL clock.
- R6: Register addresses that are neither a slot nor 0x10 are still acknowledged; writes to them change no output and reads from them return 0x00.
- R7: A START seen anywhere in a transaction, including mid-byte, drops the transaction and restarts address reception; the interrupted byte is not stored.
- R8: For each accepted byte the target holds SDA low through the ninth SCL clock and releases it afterwards; `sda_oe_o` changes only while the filtered SCL is low.
- R9: A read returns exactly one byte: after it the target releases SDA and stays off the bus until the next START or STOP, whatever the master answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_i | input | 5 | Strapped low five bits of the device address |
| freq_sel_o | output | NUM_OUTS*8 | Frequency-select byte per output, slot n at bits 8n+7:8n |
| margin_o | output | 8 | Global margin byte (register 0x10) |

## Verification
The bench builds the target with four outputs and SYNC_STAGES of two, so slot 3 is the last implemented register and addresses 0x04 to 0x0F form a reachable band of unimplemented registers between the slots and the margin byte. The strap is tied to 01011, which lets one test flip only a strap bit and another only a fixed bit of the address. Bus timing of sixteen system clocks per quarter bit keeps the filter latency well inside each SCL phase, which makes the exact cycle of the acknowledge edge and the register update observable from the ports.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int FIXED_W = 2;
  localparam int STRAP_W = ADDR_W - FIXED_W;
  localparam logic [FIXED_W-1:0] FIXED_BITS = 2'b11;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/cfg_i2c_line_filter.sv
module cfg_i2c_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic filt_o,
  output logic filt_d_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic last_q, filt_q, filt_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '1;
      last_q   <= 1'b1;
      filt_q   <= 1'b1;
      filt_d_q <= 1'b1;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], line_i};
      last_q   <= sync_q[SYNC_STAGES-1];
      // accept a level only when two consecutive samples agree
      if (last_q == sync_q[SYNC_STAGES-1]) filt_q <= last_q;
      filt_d_q <= filt_q;
    end
  end

  assign filt_o   = filt_q;
  assign filt_d_o = filt_d_q;
endmodule

// File: rtl/cfg_i2c_bus_engine.sv
module cfg_i2c_bus_engine
  import cfg_i2c_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     sda_i,
  input  logic [ADDR_W-1:0]        dev_addr_i,
  input  logic [BYTE_W-1:0]        rd_data_i,
  output logic [BYTE_W-1:0]        ptr_o,
  output logic                     wr_en_o,
  output logic [BYTE_W-1:0]        wr_data_o,
  output logic                     sda_oe_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  bus_state_e         state_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0]  shreg_q, ptr_q, wr_data_q;
  logic               ack_q, rw_q, oe_q, wr_en_q;
  logic               rx_state;

  assign rx_state = state_q inside {ST_ADDR, ST_REG, ST_WDATA};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      wr_data_q <= '0;
      ack_q     <= 1'b0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        ack_q   <= 1'b0;
        oe_q    <= 1'b0;
      end else if (scl_rise_i) begin
        if (rx_state && !ack_q && bit_cnt_q != FULL_CNT) begin
          shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (state_q == ST_RDATA && ack_q) begin
          // master answer sampled; single-byte reads only
          state_q <= ST_SKIP;
        end
      end else if (scl_fall_i) begin
        if (ack_q) begin
          ack_q     <= 1'b0;
          oe_q      <= 1'b0;
          bit_cnt_q <= '0;
          case (state_q)
            ST_ADDR: begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                shreg_q <= rd_data_i;
                oe_q    <= ~rd_data_i[BYTE_W-1];
              end else begin
                state_q <= ST_REG;
              end
            end
            ST_REG:   state_q <= ST_WDATA;
            ST_WDATA: state_q <= ST_SKIP;
            default: ;
          endcase
        end else if (rx_state && bit_cnt_q == FULL_CNT) begin
          case (state_q)
            ST_ADDR: begin
              if (shreg_q[BYTE_W-1:1] == dev_addr_i) begin
                rw_q  <= shreg_q[0];
                ack_q <= 1'b1;
                oe_q  <= 1'b1;
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_REG: begin
              ptr_q <= shreg_q;
              ack_q <= 1'b1;
              oe_q  <= 1'b1;
            end
            ST_WDATA: begin
              wr_en_q   <= 1'b1;
              wr_data_q <= shreg_q;
              ack_q     <= 1'b1;
              oe_q      <= 1'b1;
            end
            default: ;
          endcase
        end else if (state_q == ST_RDATA) begin
          if (bit_cnt_q == LAST_TX) begin
            oe_q  <= 1'b0;
            ack_q <= 1'b1;
          end else begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], 1'b0};
            oe_q      <= ~shreg_q[BYTE_W-2];
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;
  assign sda_oe_o  = oe_q;
endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile
  import cfg_i2c_pkg::*;
#(
  parameter int                NUM_OUTS    = 6,
  parameter logic [BYTE_W-1:0] MARGIN_ADDR = 8'h10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [BYTE_W-1:0]          addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [NUM_OUTS*BYTE_W-1:0] freq_o,
  output logic [BYTE_W-1:0]          margin_o
);
  logic [BYTE_W-1:0] freq_q [NUM_OUTS];
  logic [BYTE_W-1:0] margin_q;

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    freq_q[i] <= '0;
      else if (wr_en_i && addr_i == BYTE_W'(i))       freq_q[i] <= wr_data_i;
    end
    assign freq_o[i*BYTE_W +: BYTE_W] = freq_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              margin_q <= '0;
    else if (wr_en_i && addr_i == MARGIN_ADDR) margin_q <= wr_data_i;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_OUTS; i++) begin
      if (addr_i == BYTE_W'(i)) rd_data_o = freq_q[i];
    end
    if (addr_i == MARGIN_ADDR) rd_data_o = margin_q;
  end

  assign margin_o = margin_q;
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int                NUM_OUTS    = 6,
  parameter logic [BYTE_W-1:0] MARGIN_ADDR = 8'h10,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  input  logic [STRAP_W-1:0]         strap_i,
  output logic [NUM_OUTS*BYTE_W-1:0] freq_sel_o,
  output logic [BYTE_W-1:0]          margin_o
);
  logic scl_f, scl_d, sda_f, sda_d;
  logic start, stop, scl_rise, scl_fall;
  logic [BYTE_W-1:0] ptr, wr_data, rd_data;
  logic wr_en;
  logic [ADDR_W-1:0] dev_addr;

  cfg_i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES)) i_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .filt_o(scl_f), .filt_d_o(scl_d)
  );
  cfg_i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES)) i_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .filt_o(sda_f), .filt_d_o(sda_d)
  );

  // bus conditions: SDA edge while SCL held high
  assign start    = scl_f & scl_d & sda_d & ~sda_f;
  assign stop     = scl_f & scl_d & ~sda_d & sda_f;
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign dev_addr = {FIXED_BITS, strap_i};

  cfg_i2c_bus_engine i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .stop_i     (stop),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_f),
    .dev_addr_i (dev_addr),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  cfg_i2c_regfile #(.NUM_OUTS(NUM_OUTS), .MARGIN_ADDR(MARGIN_ADDR)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (ptr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .freq_o    (freq_sel_o),
    .margin_o  (margin_o)
  );
endmodule

// File: rtl/cfg_i2c_checker.sv
module cfg_i2c_checker
  import cfg_i2c_pkg::*;
#(
  parameter int                NUM_OUTS    = 6,
  parameter logic [BYTE_W-1:0] MARGIN_ADDR = 8'h10
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       scl_f_i,
  input logic                       start_i,
  input logic                       stop_i,
  input logic                       wr_en_i,
  input logic [BYTE_W-1:0]          wr_addr_i,
  input logic [BYTE_W-1:0]          wr_data_i,
  input logic                       sda_oe_i,
  input logic [NUM_OUTS*BYTE_W-1:0] freq_i,
  input logic [BYTE_W-1:0]          margin_i
);
  a_r8_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_f_i);

  a_r7_condition_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !sda_oe_i);

  a_r3_store_at_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> $rose(sda_oe_i));

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_slot_chk
    a_r3_slot_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == BYTE_W'(i)) |=> freq_i[i*BYTE_W +: BYTE_W] == $past(wr_data_i));
  end

  a_r4_margin_keeps_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == MARGIN_ADDR) |=> $stable(freq_i));

  a_r4_margin_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(margin_i) |-> ($past(wr_en_i) && $past(wr_addr_i) == MARGIN_ADDR));

  a_r6_unmapped_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= BYTE_W'(NUM_OUTS) && wr_addr_i != MARGIN_ADDR)
      |=> ($stable(freq_i) && $stable(margin_i)));
endmodule

bind cfg_i2c_target cfg_i2c_checker #(.NUM_OUTS(NUM_OUTS), .MARGIN_ADDR(MARGIN_ADDR)) i_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_f_i   (scl_f),
  .start_i   (start),
  .stop_i    (stop),
  .wr_en_i   (wr_en),
  .wr_addr_i (ptr),
  .wr_data_i (wr_data),
  .sda_oe_i  (sda_oe_o),
  .freq_i    (freq_sel_o),
  .margin_i  (margin_o)
);

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
  localparam int N = 4;
  localparam int Q = 16;
  localparam logic [6:0] DEV = 7'b1101011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [N*8-1:0] freq;
  logic [7:0] margin;
  int n_checks = 0;
  int n_fail = 0;
  int oe_cnt = 0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

  cfg_i2c_target #(.NUM_OUTS(N), .MARGIN_ADDR(8'h10), .SYNC_STAGES(2)) i_cfg_i2c_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(DEV[4:0]), .freq_sel_o(freq), .margin_o(margin)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic write_bit(input bit b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic read_bit(output bit b);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); b = sda_bus; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic write_byte(input logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) write_bit(d[i]);
    read_bit(a);
    ack = !a;
  endtask

  task automatic read_byte(output logic [7:0] d, input bit mack);
    bit b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); d[i] = b; end
    write_bit(!mack);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] ra, input logic [7:0] d,
                          output logic [2:0] acks);
    bus_start();
    write_byte({a, 1'b0}, acks[2]);
    write_byte(ra, acks[1]);
    write_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] ra, output logic [7:0] d,
                         output logic [2:0] acks);
    bus_start();
    write_byte({a, 1'b0}, acks[2]);
    write_byte(ra, acks[1]);
    bus_start();
    write_byte({a, 1'b1}, acks[0]);
    read_byte(d, 1'b0);
    bus_stop();
  endtask

  task automatic t_reset();
    check(freq == '0, "R1 slots after reset", 32'(freq), 0);
    check(margin == 8'h00, "R1 margin after reset", 32'(margin), 0);
    check(sda_oe == 1'b0, "R1 sda_oe after reset", 32'(sda_oe), 0);
  endtask

  task automatic t_write_read();
    logic [2:0] acks;
    logic [7:0] d;
    do_write(DEV, 8'h03, 8'h05, acks);
    check(acks == 3'b111, "R8 write acks", 32'(acks), 32'h7);
    check(freq[24 +: 8] == 8'h05, "R3 slot3", 32'(freq[24 +: 8]), 32'h05);
    do_write(DEV, 8'h00, 8'hA5, acks);
    do_write(DEV, 8'h01, 8'h3C, acks);
    check(freq[0 +: 8] == 8'hA5, "R3 slot0", 32'(freq[0 +: 8]), 32'hA5);
    check(freq[8 +: 8] == 8'h3C, "R3 slot1", 32'(freq[8 +: 8]), 32'h3C);
    check(freq[24 +: 8] == 8'h05, "R3 slot3 kept", 32'(freq[24 +: 8]), 32'h05);
    do_read(DEV, 8'h03, d, acks);
    check(acks == 3'b111, "R5 read acks", 32'(acks), 32'h7);
    check(d == 8'h05, "R5 read slot3", 32'(d), 32'h05);
    do_read(DEV, 8'h00, d, acks);
    check(d == 8'hA5, "R5 read slot0", 32'(d), 32'hA5);
  endtask

  task automatic t_margin();
    logic [2:0] acks;
    logic [7:0] d;
    logic [N*8-1:0] snap = freq;
    do_write(DEV, 8'h10, 8'h01, acks);
    check(margin == 8'h01, "R4 margin written", 32'(margin), 32'h01);
    check(freq == snap, "R4 slots unchanged", 32'(freq), 32'(snap));
    do_read(DEV, 8'h10, d, acks);
    check(d == 8'h01, "R4 margin readback", 32'(d), 32'h01);
  endtask

  task automatic t_unmapped();
    logic [2:0] acks;
    logic [7:0] d;
    logic [N*8-1:0] snap = freq;
    logic [7:0] msnap = margin;
    do_write(DEV, 8'h07, 8'h77, acks);
    check(acks == 3'b111, "R6 unmapped acked", 32'(acks), 32'h7);
    check(freq == snap && margin == msnap, "R6 write dropped", 32'(freq), 32'(snap));
    do_read(DEV, 8'h07, d, acks);
    check(d == 8'h00, "R6 unmapped reads zero", 32'(d), 32'h00);
  endtask

  task automatic t_wrong_addr();
    logic [2:0] acks;
    logic [N*8-1:0] snap = freq;
    int oe_snap = oe_cnt;
    do_write(7'b1101010, 8'h00, 8'hFF, acks);
    check(acks == 3'b000, "R2 strap mismatch nacked", 32'(acks), 0);
    do_write(7'b1001011, 8'h01, 8'hFF, acks);
    check(acks == 3'b000, "R2 fixed-bit mismatch nacked", 32'(acks), 0);
    check(oe_cnt == oe_snap, "R2 never drove bus", 32'(oe_cnt), 32'(oe_snap));
    check(freq == snap, "R2 slots unchanged", 32'(freq), 32'(snap));
  endtask

  task automatic t_restart();
    bit a;
    logic [2:0] acks;
    bus_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'h02, a);
    for (int i = 0; i < 4; i++) write_bit(1'b1);
    bus_start();
    write_byte({DEV, 1'b0}, acks[2]);
    write_byte(8'h01, acks[1]);
    write_byte(8'h99, acks[0]);
    bus_stop();
    check(acks == 3'b111, "R7 restart acks", 32'(acks), 32'h7);
    check(freq[8 +: 8] == 8'h99, "R7 new write lands", 32'(freq[8 +: 8]), 32'h99);
    check(freq[16 +: 8] == 8'h00, "R7 cut byte dropped", 32'(freq[16 +: 8]), 32'h00);
  endtask

  task automatic t_ack_timing();
    bit a;
    int guard = 0;
    logic [7:0] d = 8'hC3;
    bus_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'h02, a);
    for (int i = 7; i >= 1; i--) write_bit(d[i]);
    sda_m = d[0]; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0;
    while (!sda_oe && guard < 4 * Q) begin @(negedge clk); guard++; end
    check(sda_oe == 1'b1, "R8 data ack driven", 32'(sda_oe), 1);
    check(freq[16 +: 8] == 8'h00, "R3 not before ack+1", 32'(freq[16 +: 8]), 32'h00);
    @(negedge clk);
    check(freq[16 +: 8] == 8'hC3, "R3 one clock after ack", 32'(freq[16 +: 8]), 32'hC3);
    read_bit(a);
    check(a == 1'b0, "R8 ninth clock low", 32'(a), 0);
    bus_stop();
  endtask

  task automatic t_single_read();
    bit a;
    logic [7:0] d, d2;
    int oe_snap;
    bus_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'h01, a);
    bus_start();
    write_byte({DEV, 1'b1}, a);
    read_byte(d, 1'b1);
    check(d == 8'h99, "R9 first byte", 32'(d), 32'h99);
    oe_snap = oe_cnt;
    read_byte(d2, 1'b0);
    check(d2 == 8'hFF, "R9 second byte idle", 32'(d2), 32'hFF);
    check(oe_cnt == oe_snap, "R9 bus released", 32'(oe_cnt), 32'(oe_snap));
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_write_read();
    t_margin();
    t_unmapped();
    t_wrong_addr();
    t_restart();
    t_ack_timing();
    t_single_read();
    report();
    $finish;
  end
endmodule